// File: doc/BRIEF.md
# Spaced-Ones Sequence Detector

This block watches a serial bit stream and raises a one-cycle flag each time it sees three ones, with exactly two bits of any value between each one and the next. Read as a sequence, the shape is one, any, any, one, any, any, one. A bit is taken only in a cycle where its valid strobe is high. The flag is a Moore output: it comes straight from a state bit, so it is free of input glitches and it appears in the cycle that follows the edge that took the final one.

Matches never share bits. Once a match has been flagged, the search starts over. A one that arrives in the flag cycle is taken as the leading one of a new pattern. The state register holds one bit per state, with exactly one bit set.

The input is a valid-qualified stream. The detector takes a bit in every cycle, so it never applies back-pressure and has no ready output. An upstream source may drop valid for any number of cycles. The `rst` input is synchronous and active high.

Top module: `spaced_ones_detector`

## Requirements
- R1: Reset clears the detector. `match_o` reads 0 in the cycle after a reset edge. Any partial pattern is discarded, so the first accepted bit after reset counts only as a possible leading one.
- R2: When the bits 1,x,x,1,x,x,1 are accepted in that order, starting from the idle state, `match_o` is 1 in the cycle that follows the edge that took the final 1.
- R3: A bit taken at a don't-care position (the 2nd, 3rd, 5th or 6th position of the pattern) advances the search whether it is 0 or 1.
- R4: An accepted 0 at a position that needs a 1 (the 4th or 7th) returns the detector to idle. A match then needs a fresh leading 1.
- R5: `match_o` is never high for two cycles in a row.
- R6: Matches do not overlap. The stream 1001001001 yields exactly one match, and its trailing 1 opens a new pattern, which 001001 then completes.
- R7: An accepted 1 in the flag cycle counts as the leading 1 of a new pattern.
- R8: An accepted 0 in the flag cycle returns the detector to idle.
- R9: In a cycle with `bit_valid` low, `bit_in` is ignored and the search position is kept. The one exception is the flag state, which falls back to idle.
- R10: The state register is one-hot, with exactly one bit set in every cycle after reset. A long run of ones therefore flags every seventh accepted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to idle |
| bit_valid | input | 1 | High when `bit_in` carries a bit to take |
| bit_in | input | 1 | Serial data bit |
| match_o | output | 1 | One-cycle flag for a completed pattern |

## Verification
The properties assume that `rst` is held high through the first clock edge, so that the one-hot register starts from a known value. They also assume that `bit_valid` and `bit_in` are known at each edge. They make no assumption about how valid gaps are spaced or how long they last.

The stimulus changes inputs only on the falling edge and holds reset for two edges at the start. It inserts valid-low gaps inside patterns and in the flag cycle, so the hold and drop paths are driven without ever handing an unknown bit to the detector.

// File: rtl/sdet_pkg.sv
package sdet_pkg;
  // Pattern positions are numbered from 1 (the leading one).
  // A position needs a 1 when it begins a gap-sized group.
  function automatic bit is_mark(input int pos, input int gap);
    return ((pos - 1) % (gap + 1)) == 0;
  endfunction

  function automatic int last_pos(input int marks, input int gap);
    return (marks - 1) * (gap + 1) + 1;
  endfunction
endpackage

// File: rtl/sdet_next.sv
module sdet_next
  import sdet_pkg::*;
#(
  parameter int GAP   = 2,
  parameter int MARKS = 3,
  localparam int LAST = last_pos(MARKS, GAP),
  localparam int NST  = LAST + 1
) (
  input  logic [NST-1:0] cur,
  input  logic           in_valid,
  input  logic           in_bit,
  output logic [NST-1:0] nxt
);
  // fall[i]: an accepted 0 in state i sends the machine to idle
  logic [NST-1:0] fall;
  logic           restart_src;

  assign restart_src = cur[0] | cur[LAST];

  for (genvar i = 0; i < NST; i++) begin : g_fall
    if (i == 0 || i == LAST) begin : g_edge
      assign fall[i] = cur[i];
    end else if (is_mark(i + 1, GAP)) begin : g_mark
      assign fall[i] = cur[i];
    end else begin : g_free
      assign fall[i] = 1'b0;
    end
  end

  assign nxt[0] = (~in_valid & restart_src) |
                  (in_valid & ~in_bit & (|fall));
  assign nxt[1] = (in_valid & in_bit & restart_src) |
                  (~in_valid & cur[1]);

  for (genvar q = 2; q < NST; q++) begin : g_step
    logic adv;
    logic keep;
    if (is_mark(q, GAP)) begin : g_need_one
      assign adv = in_valid & in_bit & cur[q-1];
    end else begin : g_any
      assign adv = in_valid & cur[q-1];
    end
    if (q == LAST) begin : g_flag
      assign keep = 1'b0;
    end else begin : g_hold
      assign keep = ~in_valid & cur[q];
    end
    assign nxt[q] = adv | keep;
  end
endmodule

// File: rtl/sdet_state_reg.sv
module sdet_state_reg #(
  parameter int NST = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NST-1:0] nxt,
  output logic [NST-1:0] q
);
  localparam logic [NST-1:0] IDLE_HOT = NST'(1);

  always_ff @(posedge clk) begin
    if (rst) q <= IDLE_HOT;
    else     q <= nxt;
  end
endmodule

// File: rtl/spaced_ones_detector.sv
module spaced_ones_detector
  import sdet_pkg::*;
#(
  parameter int GAP   = 2,
  parameter int MARKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_in,
  output logic match_o
);
  localparam int LAST = last_pos(MARKS, GAP);
  localparam int NST  = LAST + 1;

  logic [NST-1:0] state_q;
  logic [NST-1:0] state_d;

  sdet_next #(.GAP(GAP), .MARKS(MARKS)) u_next (
    .cur      (state_q),
    .in_valid (bit_valid),
    .in_bit   (bit_in),
    .nxt      (state_d)
  );

  sdet_state_reg #(.NST(NST)) u_state (
    .clk (clk),
    .rst (rst),
    .nxt (state_d),
    .q   (state_q)
  );

  assign match_o = state_q[LAST];
endmodule

// File: rtl/sdet_checker.sv
module sdet_checker #(
  parameter int NST  = 8,
  parameter int LAST = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           bit_valid,
  input logic           bit_in,
  input logic [NST-1:0] state_q,
  input logic           match_o
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !match_o);

  a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    match_o |=> !match_o);

  a_r2_final_one: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(bit_valid && bit_in));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!bit_valid && !state_q[LAST]) |=> $stable(state_q));

  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    (match_o && bit_valid && bit_in) |=> state_q[1]);

  a_r8_flag_to_idle: assert property (@(posedge clk) disable iff (rst)
    (match_o && !(bit_valid && bit_in)) |=> state_q[0]);
endmodule

bind spaced_ones_detector sdet_checker #(.NST(NST), .LAST(LAST)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_valid (bit_valid),
  .bit_in    (bit_in),
  .state_q   (state_q),
  .match_o   (match_o)
);

// File: tb/tb_spaced_ones_detector.sv
module tb_spaced_ones_detector;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic match_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  spaced_ones_detector dut (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .match_o   (match_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {valid, bit, expected match_o after the edge, requirement number[4:0]}
  localparam logic [7:0] VEC [NV] = '{
    // R2: plain 1001001 from idle, then R8 via a 0 in the flag cycle
    8'b110_00010, 8'b100_00010, 8'b100_00010, 8'b110_00010,
    8'b100_00010, 8'b100_00010, 8'b111_00010, 8'b100_01000,
    // R3: ones at every don't-care position
    8'b110_00011, 8'b110_00011, 8'b110_00011, 8'b110_00011,
    8'b110_00011, 8'b110_00011, 8'b111_00011,
    // R7: a 1 in the flag cycle leads a new pattern 1,0,0,1,1,0,1
    8'b110_00111, 8'b100_00111, 8'b100_00111, 8'b110_00111,
    8'b110_00111, 8'b100_00111, 8'b111_00111, 8'b100_01000,
    // R4: a 0 at the 4th position goes idle, then a full pattern
    8'b110_00100, 8'b100_00100, 8'b100_00100, 8'b100_00100,
    8'b110_00100, 8'b100_00100, 8'b100_00100, 8'b110_00100,
    8'b100_00100, 8'b100_00100, 8'b111_00100, 8'b100_01000,
    // R4: a 0 at the 7th position gives no match
    8'b110_00100, 8'b100_00100, 8'b100_00100, 8'b110_00100,
    8'b100_00100, 8'b100_00100, 8'b100_00100,
    // R9: valid-low gaps hold position; the flag drops after one cycle
    8'b110_01001, 8'b010_01001, 8'b100_01001, 8'b000_01001,
    8'b100_01001, 8'b110_01001, 8'b010_01001, 8'b100_01001,
    8'b100_01001, 8'b111_01001, 8'b010_00101, 8'b010_01001,
    // R6: the stream 1001001001, a single match
    8'b110_00110, 8'b100_00110, 8'b100_00110, 8'b110_00110,
    8'b100_00110, 8'b100_00110, 8'b111_00110, 8'b100_00110,
    8'b100_00110, 8'b110_00110
  };

  task automatic check(input logic exp, input int rq);
    checks++;
    if (match_o !== exp) begin
      fails++;
      $display("FAIL R%0d: match_o=%b expected %b at %0t", rq, match_o, exp, $time);
    end
  endtask

  // Called at a falling edge: drive, wait through the rising edge, sample.
  task automatic step(input logic v, input logic b, input logic exp, input int rq);
    bit_valid = v;
    bit_in    = b;
    @(negedge clk);
    check(exp, rq);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(1'b0, 1); // R1 reset state
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][7], VEC[i][6], VEC[i][5], int'(VEC[i][4:0]));
    end

    // R6: the trailing 1 above opened a new pattern; 001001 completes it
    step(1'b1, 1'b0, 1'b0, 6);
    step(1'b1, 1'b0, 1'b0, 6);
    step(1'b1, 1'b1, 1'b0, 6);
    step(1'b1, 1'b0, 1'b0, 6);
    step(1'b1, 1'b0, 1'b0, 6);
    step(1'b1, 1'b1, 1'b1, 6);
    step(1'b1, 1'b0, 1'b0, 8);

    // R1: reset in the middle of a pattern discards it
    step(1'b1, 1'b1, 1'b0, 1);
    step(1'b1, 1'b0, 1'b0, 1);
    step(1'b1, 1'b0, 1'b0, 1);
    step(1'b1, 1'b1, 1'b0, 1);
    step(1'b1, 1'b0, 1'b0, 1);
    step(1'b1, 1'b0, 1'b0, 1);
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b0, 1);
    rst = 1'b0;
    step(1'b1, 1'b1, 1'b0, 1); // would complete a match without the reset
    step(1'b1, 1'b0, 1'b0, 1);
    step(1'b1, 1'b0, 1'b0, 1);
    step(1'b1, 1'b1, 1'b0, 1);
    step(1'b1, 1'b0, 1'b0, 1);
    step(1'b1, 1'b0, 1'b0, 1);
    step(1'b1, 1'b1, 1'b1, 1);
    step(1'b1, 1'b0, 1'b0, 8);

    // R10 and R5: a long run of ones flags every seventh bit, never twice in a row
    for (int k = 0; k < 35; k++) begin
      step(1'b1, 1'b1, (k % 7) == 6, 10);
    end
    step(1'b0, 1'b0, 1'b0, 5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule